// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Aligner

This block sits between a 32-bit instruction memory port and an instruction decoder. Memory is read one aligned word per fetch cycle. The block turns that word stream into whole instructions of 16, 24 or 32 bits, handed to the decoder one per cycle over a valid/ready pair. A two-bit mode input picks the set of lengths in use: word-only, 32/16, or 32/24/16. In the 32/24/16 set an instruction may begin on any byte. One fetched word can then carry the tail of one instruction, a whole short one and the head of another.

Fetched bytes go into a small byte queue. The length of the instruction at the head of the queue is decoded from the upper nibble of its first byte. An instruction is offered once all of its bytes are present, so bytes left over from one word are joined with the leading bytes of the next word. A redirect to any byte address empties the queue and restarts fetching at the word that holds the target. The bytes of that first word that lie below the target are dropped. When the decoder holds ready low, everything freezes: the output, the queue and the fetch address.

Top module: `vl_fetch_aligner`

## Requirements
- R1: After reset `ins_valid_o` is low, `mem_addr_o` equals the reset address (0 by default), and fetching starts at once when `ins_ready_i` is high.
- R2: `mem_addr_o` is always word aligned. Outside a redirect it advances by exactly 4 after each cycle in which `mem_en_o` is high, and it holds otherwise.
- R3: In mode 0 (word-only) every issued instruction has length code 2 (32 bits) and comes from one word. With ready held high, one instruction issues every cycle after the first fetch.
- R4: The length is decoded from bits [7:4] of the instruction's first byte. In modes 1 and 2, a nibble with bit 3 set means 16 bits. In mode 2 only, nibbles 0101, 0110 and 0111 mean 24 bits. Every other case means 32 bits, including 0101 to 0111 in mode 1.
- R5: Byte order is little-endian. The byte at the lowest address appears in `ins_data_o[31:24]`, and the following bytes fill downward. Bits beyond the instruction's length are zero. `ins_len_o` is 0 for 16 bits, 1 for 24 bits and 2 for 32 bits.
- R6: An instruction that crosses a word boundary is issued intact once the next word has been fetched. Instructions issue in address order with none lost or repeated.
- R7: On `redir_i` the queue is emptied and the word holding `redir_addr_i` is fetched next. The first issued instruction starts exactly at the target byte. In mode 0 the two low target bits are ignored.
- R8: While `ins_valid_o` is high and `ins_ready_i` is low, the next cycle shows the same data, length and valid, and `mem_addr_o` does not move.
- R9: In a redirect cycle no instruction is consumed, and `ins_valid_o` is low in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Length set: 0 word-only, 1 32/16, 2 or 3 32/24/16 |
| redir_i | input | 1 | Redirect fetch to `redir_addr_i` |
| redir_addr_i | input | ADDR_W | Byte address of the redirect target |
| mem_en_o | output | 1 | A word is read from `mem_addr_o` this cycle |
| mem_addr_o | output | ADDR_W | Word-aligned byte address of the fetch |
| mem_rdata_i | input | 32 | Word read at `mem_addr_o`, little-endian, same cycle |
| ins_valid_o | output | 1 | A complete instruction is offered |
| ins_ready_i | input | 1 | Decoder accepts the offered instruction |
| ins_data_o | output | 32 | Instruction, first byte in bits [31:24], zero padded |
| ins_len_o | output | 2 | Length code: 0 = 16, 1 = 24, 2 = 32 bits |

## Verification
A wrong byte count or head position in the queue shows up at the decoder port on the very next instruction. It appears as a wrong length code, shifted bytes or a skipped or repeated instruction, and every later instruction in the stream stays misaligned until the next redirect. A wrong discard offset after a redirect shows in the first issued instruction, because the bytes below the target are filled with a pattern that decodes as a 16-bit instruction. A fetch address that slips or moves during a stall shows within one cycle on `mem_addr_o`, and a few instructions later as wrong content.

// File: rtl/vlfa_pkg.sv
package vlfa_pkg;

   // fetch length sets
   localparam logic [1:0] MODE_WORD  = 2'd0;
   localparam logic [1:0] MODE_HALF  = 2'd1;
   localparam logic [1:0] MODE_TRI   = 2'd2;

   typedef enum logic [1:0] {
      LEN_16 = 2'd0,
      LEN_24 = 2'd1,
      LEN_32 = 2'd2
   } len_code_e;

   function automatic logic [2:0] len_to_bytes(input len_code_e c);
      case (c)
         LEN_16:  len_to_bytes = 3'd2;
         LEN_24:  len_to_bytes = 3'd3;
         default: len_to_bytes = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/vlfa_len_dec.sv
module vlfa_len_dec
   import vlfa_pkg::*;
#(
   parameter bit ALLOW_24 = 1'b1
) (
   input  logic [1:0] mode_i,
   input  logic [7:0] first_byte_i,
   output len_code_e  len_o
);

   logic [3:0] nib;
   logic       short_fmt;
   logic       tri_fmt;
   logic       tri_en;

   assign nib       = first_byte_i[7:4];
   assign short_fmt = nib[3];
   assign tri_fmt   = (nib == 4'b0101) || (nib == 4'b0110) || (nib == 4'b0111);

   generate
      if (ALLOW_24) begin : g_tri
         assign tri_en = mode_i[1];
      end else begin : g_no_tri
         assign tri_en = 1'b0;
      end
   endgenerate

   always_comb begin
      if (mode_i == MODE_WORD) begin
         len_o = LEN_32;
      end else if (short_fmt) begin
         len_o = LEN_16;
      end else if (tri_en && tri_fmt) begin
         len_o = LEN_24;
      end else begin
         len_o = LEN_32;
      end
   end

endmodule

// File: rtl/vlfa_addr_gen.sv
module vlfa_addr_gen #(
   parameter int unsigned     ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_i,
   input  logic              redir_i,
   input  logic [ADDR_W-1:0] redir_addr_i,
   input  logic              adv_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [1:0]        skip_o
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

   generate
      if (ADDR_W < 3) begin : g_bad_w
         $error("vlfa_addr_gen: ADDR_W must be at least 3");
      end
      if (RESET_ADDR[1:0] != 2'b00) begin : g_bad_rst
         $error("vlfa_addr_gen: RESET_ADDR must be word aligned");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_q;
   logic [1:0]        skip_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= RESET_ADDR;
         skip_q <= 2'b00;
      end else if (redir_i) begin
         addr_q <= {redir_addr_i[ADDR_W-1:2], 2'b00};
         skip_q <= (mode_i == 2'd0) ? 2'b00 : redir_addr_i[1:0];
      end else if (adv_i) begin
         addr_q <= addr_q + STEP;
         skip_q <= 2'b00;
      end
   end

   assign addr_o = addr_q;
   assign skip_o = skip_q;

   // R2
   addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_q[1:0] == 2'b00);

   // R2
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!redir_i && !adv_i) |=> $stable(addr_q));

   // R7
   redir_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redir_i |=> (addr_q[ADDR_W-1:2] == $past(redir_addr_i[ADDR_W-1:2])));

endmodule

// File: rtl/vlfa_byte_buf.sv
module vlfa_byte_buf #(
   parameter int unsigned BUF_BYTES = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          flush_i,
   input  logic [2:0]                    pop_i,
   input  logic                          push_i,
   input  logic [31:0]                   word_i,
   input  logic [1:0]                    skip_i,
   output logic [31:0]                   head_o,
   output logic [$clog2(BUF_BYTES+1)-1:0] cnt_o,
   output logic                          room_o
);

   localparam int unsigned CNT_W = $clog2(BUF_BYTES + 1);
   localparam int unsigned IW    = $clog2(BUF_BYTES + 5);
   localparam int unsigned BW    = BUF_BYTES * 8;

   generate
      if (BUF_BYTES < 7) begin : g_bad_depth
         $error("vlfa_byte_buf: BUF_BYTES must be at least 7");
      end
   endgenerate

   logic [BW-1:0]    buf_q;
   logic [CNT_W-1:0] cnt_q;
   logic [IW-1:0]    rem;
   logic [IW-1:0]    take;
   logic [BW-1:0]    shifted;
   logic [31:0]      wsh;
   logic [7:0]       nxt_b [BUF_BYTES];

   assign rem     = IW'(cnt_q) - IW'(pop_i);
   assign take    = push_i ? (IW'(4) - IW'(skip_i)) : '0;
   assign room_o  = (rem + IW'(4)) <= IW'(BUF_BYTES);
   assign shifted = buf_q >> {pop_i, 3'b000};
   assign wsh     = word_i >> {skip_i, 3'b000};

   generate
      for (genvar i = 0; i < int'(BUF_BYTES); i++) begin : g_byte
         localparam logic [IW-1:0] POS = IW'(i);
         logic [IW-1:0] woff;
         assign woff = POS - rem;
         assign nxt_b[i] = (POS < rem)        ? shifted[8*i +: 8] :
                           (POS < rem + take) ? wsh[{woff[1:0], 3'b000} +: 8] :
                                                8'h00;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         buf_q <= '0;
      end else if (flush_i) begin
         cnt_q <= '0;
         buf_q <= '0;
      end else begin
         cnt_q <= CNT_W'(rem + take);
         for (int i = 0; i < int'(BUF_BYTES); i++) begin
            buf_q[8*i +: 8] <= nxt_b[i];
         end
      end
   end

   assign head_o = buf_q[31:0];
   assign cnt_o  = cnt_q;

   // R6
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(BUF_BYTES));

   // R6
   pop_covered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      IW'(pop_i) <= IW'(cnt_q));

   // R2
   push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !flush_i) |-> room_o);

   // R9
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (cnt_q == '0));

endmodule

// File: rtl/vl_fetch_aligner.sv
module vl_fetch_aligner
   import vlfa_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 16,
   parameter int unsigned       BUF_BYTES  = 8,
   parameter bit                ALLOW_24   = 1'b1,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_i,
   input  logic              redir_i,
   input  logic [ADDR_W-1:0] redir_addr_i,
   output logic              mem_en_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic [31:0]       mem_rdata_i,
   output logic              ins_valid_o,
   input  logic              ins_ready_i,
   output logic [31:0]       ins_data_o,
   output logic [1:0]        ins_len_o
);

   localparam int unsigned CNT_W = $clog2(BUF_BYTES + 1);

   logic [31:0]      head;
   logic [CNT_W-1:0] cnt;
   logic             room;
   logic [1:0]       skip;
   len_code_e        len;
   logic [2:0]       need;
   logic [2:0]       pop;
   logic             fire;
   logic             fetch;

   vlfa_len_dec #(
      .ALLOW_24 (ALLOW_24)
   ) u_len (
      .mode_i       (mode_i),
      .first_byte_i (head[7:0]),
      .len_o        (len)
   );

   assign need        = len_to_bytes(len);
   assign ins_valid_o = cnt >= CNT_W'(need);
   assign fire        = ins_valid_o && ins_ready_i && !redir_i;
   assign pop         = fire ? need : 3'd0;
   assign fetch       = !redir_i && ins_ready_i && room;

   vlfa_byte_buf #(
      .BUF_BYTES (BUF_BYTES)
   ) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (redir_i),
      .pop_i   (pop),
      .push_i  (fetch),
      .word_i  (mem_rdata_i),
      .skip_i  (skip),
      .head_o  (head),
      .cnt_o   (cnt),
      .room_o  (room)
   );

   vlfa_addr_gen #(
      .ADDR_W     (ADDR_W),
      .RESET_ADDR (RESET_ADDR)
   ) u_addr (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_i       (mode_i),
      .redir_i      (redir_i),
      .redir_addr_i (redir_addr_i),
      .adv_i        (fetch),
      .addr_o       (mem_addr_o),
      .skip_o       (skip)
   );

   assign mem_en_o   = fetch;
   assign ins_len_o  = len;
   assign ins_data_o = {head[7:0],
                        head[15:8],
                        (len != LEN_16) ? head[23:16] : 8'h00,
                        (len == LEN_32) ? head[31:24] : 8'h00};

   // R3
   word_mode_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid_o && mode_i == MODE_WORD) |-> (ins_len_o == 2'd2));

   // R5
   pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid_o && ins_len_o == 2'd0) |-> (ins_data_o[15:0] == 16'h0000));

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid_o && !ins_ready_i && !redir_i) |=>
         (ins_valid_o && $stable(ins_data_o) && $stable(ins_len_o)));

   // R8
   stall_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ins_ready_i && !redir_i) |=> $stable(mem_addr_o));

   // R9
   redir_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redir_i |=> !ins_valid_o);

endmodule

// File: tb/tb_vl_fetch_aligner.sv
module tb_vl_fetch_aligner;

   localparam int N = 40;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  mode;
   logic        redir;
   logic [15:0] redir_addr;
   logic        mem_en;
   logic [15:0] mem_addr;
   logic [31:0] mem_rdata;
   logic        ins_valid;
   logic        ins_ready;
   logic [31:0] ins_data;
   logic [1:0]  ins_len;

   logic [7:0]  img [256];
   int          exp_addr [N];
   int          exp_len [N];
   int          checks = 0;
   int          errors = 0;
   int          cyc = 0;
   logic [7:0]  ma;

   always #4 clk = ~clk;

   assign ma        = mem_addr[7:0];
   assign mem_rdata = {img[ma + 8'd3], img[ma + 8'd2], img[ma + 8'd1], img[ma]};

   vl_fetch_aligner dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_i       (mode),
      .redir_i      (redir),
      .redir_addr_i (redir_addr),
      .mem_en_o     (mem_en),
      .mem_addr_o   (mem_addr),
      .mem_rdata_i  (mem_rdata),
      .ins_valid_o  (ins_valid),
      .ins_ready_i  (ins_ready),
      .ins_data_o   (ins_data),
      .ins_len_o    (ins_len)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected<150000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // program image: lengths and opcodes computed per mode
   task automatic build(input int m, input int start, input int seed);
      int pc;
      for (int i = 0; i < 256; i++) img[i] = 8'hFF;
      pc = start;
      for (int k = 0; k < N; k++) begin
         int L;
         int sel;
         logic [3:0] nib;
         if (m == 0) begin
            L = 4; nib = 4'(k % 5);
         end else if (m == 1) begin
            sel = (k * 7 + seed) % 4;
            if (sel < 2)       begin L = 2; nib = 4'(8 + k % 8); end
            else if (sel == 2) begin L = 4; nib = 4'(k % 5); end
            else               begin L = 4; nib = 4'(5 + k % 3); end
         end else begin
            sel = (k * 5 + seed) % 3;
            if (sel == 0)      begin L = 2; nib = 4'(8 + k % 8); end
            else if (sel == 1) begin L = 3; nib = 4'(5 + k % 3); end
            else               begin L = 4; nib = 4'(k % 5); end
         end
         exp_addr[k] = pc;
         exp_len[k]  = L;
         img[pc] = {nib, 4'(k)};
         for (int j = 1; j < L; j++) img[pc + j] = 8'((k * 37 + j * 11 + 3) & 255);
         pc += L;
      end
   endtask

   function automatic logic [31:0] exp_word(input int k);
      int a;
      int L;
      a = exp_addr[k];
      L = exp_len[k];
      exp_word = {img[a], img[a + 1], (L >= 3) ? img[a + 2] : 8'h00,
                  (L == 4) ? img[a + 3] : 8'h00};
   endfunction

   function automatic bit rdy_pat(input int rp, input int g);
      if (rp == 0) rdy_pat = 1'b1;
      else if (rp == 1) rdy_pat = (g % 3) != 1;
      else rdy_pat = (g % 5) < 2;
   endfunction

   task automatic run_case(input int m, input int off, input int rp);
      int k;
      int g;
      bit first;
      bit p_en;
      bit p_hold;
      logic [15:0] p_addr;
      logic [31:0] p_data;
      logic [1:0]  p_len;
      int target;
      target = 16 + off;
      build(m, (m == 0) ? 16 : target, off + rp);
      @(negedge clk);
      mode = 2'(m); redir = 1'b1; redir_addr = 16'(target); ins_ready = 1'b1;
      @(negedge clk);
      redir = 1'b0;
      #1;
      // R9: nothing offered right after a redirect
      chk(ins_valid == 1'b0, "R9 valid after redirect", 64'(ins_valid), 64'd0);
      // R7: fetch restarts at the word holding the target
      chk(mem_addr == 16'(target & ~3), "R7 fetch word after redirect",
          64'(mem_addr), 64'(target & ~3));
      k = 0; g = 0; first = 1'b1;
      p_en = 1'b0; p_hold = 1'b0; p_addr = '0; p_data = '0; p_len = '0;
      while (k < N && g < 600) begin
         ins_ready = rdy_pat(rp, g);
         #1;
         if (mem_addr[1:0] != 2'b00)
            chk(1'b0, "R2 alignment", 64'(mem_addr), 64'(mem_addr & ~16'd3));
         if (!first) begin
            logic [15:0] ea;
            ea = p_en ? p_addr + 16'd4 : p_addr;
            if (mem_addr != ea) chk(1'b0, "R2 address step", 64'(mem_addr), 64'(ea));
            if (p_hold) begin
               chk(ins_valid && ins_data == p_data && ins_len == p_len,
                   "R8 hold under stall", {ins_valid, ins_len, ins_data},
                   {1'b1, p_len, p_data});
               chk(!p_en, "R8 no fetch under stall", 64'(p_en), 64'd0);
            end
         end
         if (ins_valid && ins_ready) begin
            string tag;
            if (k == 0) tag = "R7 first instruction at target";
            else if (m == 0) tag = "R3 word mode instruction";
            else if (exp_len[k] == 3) tag = "R4 24-bit decode";
            else tag = "R6 R5 joined instruction";
            chk(ins_data == exp_word(k) && ins_len == 2'(exp_len[k] - 2), tag,
                {30'd0, ins_len, ins_data}, {30'd0, 2'(exp_len[k] - 2), exp_word(k)});
            k++;
         end
         p_en = mem_en; p_addr = mem_addr; p_hold = ins_valid && !ins_ready;
         p_data = ins_data; p_len = ins_len; first = 1'b0;
         @(negedge clk);
         g++;
      end
      chk(k == N, "R6 all instructions issued", 64'(k), 64'(N));
      if (m == 0 && rp == 0)
         chk(g == N + 1, "R3 one per cycle", 64'(g), 64'(N + 1));
   endtask

   initial begin
      for (int i = 0; i < 256; i++) img[i] = 8'hFF;
      rst_n = 1'b0; mode = 2'd0; redir = 1'b0; redir_addr = '0; ins_ready = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk(ins_valid == 1'b0, "R1 valid low at reset", 64'(ins_valid), 64'd0);
      chk(mem_addr == 16'd0, "R1 reset address", 64'(mem_addr), 64'd0);
      chk(mem_en == 1'b1, "R1 fetch starts", 64'(mem_en), 64'd1);
      for (int m = 0; m < 3; m++)
         for (int off = 0; off < 4; off++)
            for (int rp = 0; rp < 3; rp++)
               run_case(m, off, rp);
      // R4: mode 3 behaves like mode 2
      run_case(3, 1, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule